// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit

This unit takes one operand per request and moves it by exactly one bit position. A 4-bit select chooses the operation. Seven operations shift or rotate the operand: a logical shift to the left, a logical shift to the right, an arithmetic shift to the right, left and right rotates that wrap the word onto itself, and left and right rotates that put the carry flag into the ring. Every one of these writes a new result and a new carry out, and sets zero and sign flags from the new result.

Two more operations only examine the operand and write no result. The operand check reports whether the operand is zero and what its top bit is. The bit check ANDs the operand with a mask and reports whether any of the selected bits is set. During both checks the carry passes through unchanged and the result register keeps its value.

All outputs come from registers and change one clock after the request. A caller that tracks the carry feeds `carry_o` back into `carry_i`.

Top module: `shr_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first request, `result_o`, `carry_o`, `zero_o`, `sign_o` and `res_valid_o` are all 0.
- R2: Op code 0 (logical left): the result is the operand moved up one place with 0 in bit 0, and the carry is the old top bit.
- R3: Op code 1 (logical right): the result is the operand moved down one place with 0 in the top bit, and the carry is the old bit 0.
- R4: Op code 2 (arithmetic right): the result is the operand moved down one place with the old top bit kept in the top bit, and the carry is the old bit 0.
- R5: Op codes 3 (rotate left) and 4 (rotate right): the bit pushed out at one end enters at the other end and is also copied to the carry.
- R6: Op codes 5 (left through carry) and 6 (right through carry): the incoming carry enters the vacated end (bit 0 for left, the top bit for right), and the bit pushed out becomes the new carry.
- R7: After op codes 0 to 6, `zero_o` is 1 exactly when the new result is 0, `sign_o` equals the top bit of the new result, and `res_valid_o` is 1 for that one cycle.
- R8: Op code 7 (operand check): `zero_o` is 1 exactly when the operand is 0, `sign_o` is the operand's top bit, `carry_o` takes `carry_i`, `res_valid_o` is 0 and `result_o` keeps its previous value.
- R9: Op code 8 (bit check): with t = operand AND mask, `zero_o` is 1 exactly when t is 0, `sign_o` is the top bit of t, `carry_o` takes `carry_i`, `res_valid_o` is 0 and `result_o` keeps its previous value.
- R10: In a cycle with `valid_i` low, `res_valid_o` goes to 0 on the next clock and all other outputs keep their values.
- R11: Op codes 9 to 15 are reserved: `res_valid_o` is 0, `result_o` keeps its value, `carry_o` takes `carry_i`, and `zero_o` and `sign_o` are 0.
- R12: All outputs reflect a request one clock edge after the edge at which the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A request is present this cycle |
| op_i | input | 4 | Operation select |
| operand_i | input | WIDTH | Operand |
| mask_i | input | WIDTH | Bit-check mask; a 1 selects a bit to test |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Registered carry flag |
| zero_o | output | 1 | Registered zero flag |
| sign_o | output | 1 | Registered sign flag |
| res_valid_o | output | 1 | The result was written by the last request |

## Verification
A carry update and the zero flag can happen in the same cycle. This occurs when the only set bit leaves the word, for example a left shift or left rotate through carry of 0x80 with carry 0, or a right rotate through carry of 0x01. Directed requests of this kind are checked for a zero result, a set carry and a set zero flag all on the same cycle. Random traffic, with carry fed back from the previous result, mixes check operations between the shifts, so a held carry or a held result after a check is compared against a model that carries the previous state forward.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned OP_W = 4;
  localparam logic [OP_W-1:0] OP_SHL = 4'd0;
  localparam logic [OP_W-1:0] OP_SHR = 4'd1;
  localparam logic [OP_W-1:0] OP_SAR = 4'd2;
  localparam logic [OP_W-1:0] OP_ROL = 4'd3;
  localparam logic [OP_W-1:0] OP_ROR = 4'd4;
  localparam logic [OP_W-1:0] OP_RCL = 4'd5;
  localparam logic [OP_W-1:0] OP_RCR = 4'd6;
  localparam logic [OP_W-1:0] OP_TST = 4'd7;
  localparam logic [OP_W-1:0] OP_BIT = 4'd8;

  function automatic logic is_move(input logic [OP_W-1:0] op);
    return op <= OP_RCR;
  endfunction

  function automatic logic is_left(input logic [OP_W-1:0] op);
    return (op == OP_SHL) || (op == OP_ROL) || (op == OP_RCL);
  endfunction
endpackage

// File: rtl/shr_core.sv
module shr_core
  import shr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic fill;
  logic [WIDTH-1:0] up, down;

  // neighbour wiring per bit; the fill bit enters at the vacated end
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign up[i]   = fill;
      assign down[i] = a_i[i+1];
    end else if (i == MSB) begin : g_hi
      assign up[i]   = a_i[i-1];
      assign down[i] = fill;
    end else begin : g_mid
      assign up[i]   = a_i[i-1];
      assign down[i] = a_i[i+1];
    end
  end

  always_comb begin
    unique case (op_i)
      OP_SAR, OP_ROL: fill = a_i[MSB];
      OP_ROR:         fill = a_i[0];
      OP_RCL, OP_RCR: fill = cin_i;
      default:        fill = 1'b0;
    endcase
  end

  assign res_o  = is_left(op_i) ? up : down;
  assign cout_o = is_left(op_i) ? a_i[MSB] : a_i[0];
endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             zero_o,
  output logic             sign_o
);
  logic [WIDTH-1:0] probe;
  logic             known;

  always_comb begin
    known = 1'b1;
    if (is_move(op_i))        probe = res_i;
    else if (op_i == OP_TST)  probe = a_i;
    else if (op_i == OP_BIT)  probe = a_i & mask_i;
    else begin
      probe = '0;
      known = 1'b0;
    end
  end

  assign zero_o = known && (probe == '0);
  assign sign_o = probe[WIDTH-1];
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             res_valid_o
);
  logic [WIDTH-1:0] core_res;
  logic             core_cout, flag_z, flag_s, move;

  shr_core #(.WIDTH(WIDTH)) u_core (
    .op_i  (op_i),
    .a_i   (operand_i),
    .cin_i (carry_i),
    .res_o (core_res),
    .cout_o(core_cout)
  );

  shr_flags #(.WIDTH(WIDTH)) u_flags (
    .op_i  (op_i),
    .res_i (core_res),
    .a_i   (operand_i),
    .mask_i(mask_i),
    .zero_o(flag_z),
    .sign_o(flag_s)
  );

  assign move = is_move(op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      carry_o     <= 1'b0;
      zero_o      <= 1'b0;
      sign_o      <= 1'b0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i && move;
      if (valid_i) begin
        if (move) result_o <= core_res;
        carry_o <= move ? core_cout : carry_i;
        zero_o  <= flag_z;
        sign_o  <= flag_s;
      end
    end
  end
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk
  import shr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] operand_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             res_valid_o
);
  p_shl_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SHL |=> carry_o == $past(operand_i[WIDTH-1]) && !result_o[0]);

  p_sar_keep_msb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SAR |=> result_o[WIDTH-1] == $past(operand_i[WIDTH-1]));

  p_rcl_carry_in_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_RCL |=> result_o[0] == $past(carry_i));

  p_check_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_TST || op_i == OP_BIT)
    |=> $stable(result_o) && !res_valid_o && carry_o == $past(carry_i));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && $stable(result_o) && $stable(carry_o));

  p_reserved_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > OP_BIT |=> !res_valid_o && $stable(result_o));
endmodule

bind shr_unit shr_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .operand_i  (operand_i),
  .carry_i    (carry_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .res_valid_o(res_valid_o)
);

// File: tb/shr_unit_test.sv
module shr_unit_test;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, carry_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [W-1:0] operand_i = '0, mask_i = '0;
  logic [W-1:0] result_o;
  logic carry_o, zero_o, sign_o, res_valid_o;

  int checks = 0, errors = 0;
  logic [W-1:0] e_res = '0;
  logic e_c = 1'b0, e_z = 1'b0, e_s = 1'b0, e_v = 1'b0;

  always #4 clk = ~clk;

  shr_unit #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .mask_i(mask_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o),
    .sign_o(sign_o), .res_valid_o(res_valid_o)
  );

  function automatic string tag(input logic v, input logic [3:0] op);
    if (!v) return "R10";
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4";
      3, 4: return "R5";  5, 6: return "R6";
      7: return "R8";  8: return "R9";
      default: return "R11";
    endcase
  endfunction

  // reference model: updates e_* from the requirements
  task automatic model(input logic v, input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] m, input logic ci);
    logic [W-1:0] r, t;
    e_v = 1'b0;
    if (!v) return;
    r = '0;
    case (op)
      0: begin r = {a[W-2:0], 1'b0};    e_c = a[W-1]; end
      1: begin r = {1'b0, a[W-1:1]};    e_c = a[0];   end
      2: begin r = {a[W-1], a[W-1:1]};  e_c = a[0];   end
      3: begin r = {a[W-2:0], a[W-1]};  e_c = a[W-1]; end
      4: begin r = {a[0], a[W-1:1]};    e_c = a[0];   end
      5: begin r = {a[W-2:0], ci};      e_c = a[W-1]; end
      6: begin r = {ci, a[W-1:1]};      e_c = a[0];   end
      default: e_c = ci;
    endcase
    if (op <= 6) begin
      e_res = r; e_v = 1'b1; e_z = (r == '0); e_s = r[W-1];
    end else if (op == 7) begin
      e_z = (a == '0); e_s = a[W-1];
    end else if (op == 8) begin
      t = a & m; e_z = (t == '0); e_s = t[W-1];
    end else begin
      e_z = 1'b0; e_s = 1'b0;
    end
  endtask

  task automatic compare(input string req);
    logic [W+3:0] act, exp;
    act = {res_valid_o, result_o, carry_o, zero_o, sign_o};
    exp = {e_v, e_res, e_c, e_z, e_s};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {vld,res,c,z,s} actual %h expected %h (R12 timing)", req, act, exp);
    end
  endtask

  // drive at negedge, registered outputs are checked at the following negedge
  task automatic do_op(input logic v, input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] m, input logic ci);
    valid_i = v; op_i = op; operand_i = a; mask_i = m; carry_i = ci;
    @(negedge clk);
    model(v, op, a, m, ci);
    compare(tag(v, op));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    // directed: carry and zero in the same cycle
    do_op(1, 4'd0, 8'h80, 8'h00, 1'b0);   // R2
    do_op(1, 4'd5, 8'h80, 8'h00, 1'b0);   // R6 R7
    do_op(1, 4'd6, 8'h01, 8'h00, 1'b0);   // R6
    do_op(1, 4'd1, 8'h81, 8'h00, 1'b1);   // R3
    do_op(1, 4'd2, 8'h81, 8'h00, 1'b0);   // R4: 0xC0 c1 s1
    do_op(1, 4'd3, 8'h81, 8'h00, 1'b0);   // R5
    do_op(1, 4'd4, 8'h01, 8'h00, 1'b0);   // R5
    do_op(1, 4'd5, 8'h00, 8'h00, 1'b1);   // R6: 0x01
    do_op(1, 4'd7, 8'h00, 8'h00, 1'b1);   // R8 zero operand, carry passes
    do_op(1, 4'd7, 8'h90, 8'h00, 1'b0);   // R8 sign
    do_op(1, 4'd8, 8'hF0, 8'h0F, 1'b1);   // R9 no selected bit set
    do_op(1, 4'd8, 8'hF0, 8'h80, 1'b0);   // R9
    do_op(0, 4'd0, 8'hFF, 8'hFF, 1'b1);   // R10
    do_op(1, 4'd12, 8'h55, 8'hFF, 1'b1);  // R11
    do_op(1, 4'd15, 8'h00, 8'h00, 1'b0);  // R11

    for (int n = 0; n < 600; n++) begin
      logic v;
      logic [3:0] op;
      v  = ($urandom % 8) != 0;
      op = (($urandom % 10) == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
      do_op(v, op, W'($urandom), W'($urandom), (($urandom % 4) == 0) ? ~e_c : e_c);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule